// File: doc/BRIEF.md
# Inter-Processor Interrupt Send Command Router

This block takes a 32-bit send command written by any core and turns it into a single set-bit write aimed at one core's interrupt status register. The command holds a 10-bit target identifier and a 5-bit vector. The router pulls out both fields and checks that the target exists. When it does, the vector becomes a one-hot 32-bit mask and is presented with the target's core index for exactly one cycle. The per-core status logic downstream ORs this mask into its status and applies its own rule for raising the interrupt, as it does for any ordinary set write.

A target identifier at or above the core count produces a decode error and no write. So does an identifier that is in range but names a slot with no core fitted. The error flag comes out of the same register stage as the write pulse, one cycle after the command strobe. The core count and the map of fitted slots are parameters. The identifier indexes the core directly.

Top module: `ipi_cmd_router`

## Requirements
- R1: While rst_ni is low, and after it rises until the first command, set_vld_o and err_o are 0, set_mask_o is all zeros and set_core_o is 0.
- R2: A command strobed in cycle N that targets a fitted core in range gives set_vld_o = 1 in cycle N+1 for that one cycle only. In that cycle set_core_o equals command bits 25:16.
- R3: With set_vld_o = 1, set_mask_o has exactly one bit set, at the position given by command bits 4:0. For example, vector 31 gives 32'h8000_0000.
- R4: A command whose bits 25:16 are at or above CORE_CNT gives err_o = 1 in cycle N+1 for one cycle, with set_vld_o = 0 and set_mask_o = 0. This covers both the boundary value CORE_CNT and the value 1023.
- R5: A command whose target is in range but whose bit in POP_MASK is 0 (bit i stands for core i) gives err_o = 1 with set_vld_o = 0 and set_mask_o = 0.
- R6: Command bits 31:26 and 15:5 have no effect on the outputs.
- R7: In a cycle with cmd_vld_i = 0, the next cycle shows set_vld_o = 0, err_o = 0 and set_mask_o = 0.
- R8: Commands strobed in consecutive cycles each give their own result in the cycle that follows, with no loss and no merging.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cmd_vld_i | input | 1 | Command strobe, one command per cycle |
| cmd_i | input | 32 | Command word: target in bits 25:16, vector in bits 4:0 |
| set_vld_o | output | 1 | One-cycle set write pulse |
| set_core_o | output | IDX_W | Target core index for the set write |
| set_mask_o | output | 32 | One-hot bit mask for the set write |
| err_o | output | 1 | One-cycle decode error response |

## Verification
Every path through the block ends in a single register stage, so a fault in field extraction, range checking or mask generation shows at the ports in the cycle right after the strobe. It appears as a wrong index, a mask with no bit or two bits set, a write and an error raised together, or a write that should have been an error. A stuck register shows as a pulse that lasts past one cycle, or as output while no command is being strobed. The stimulus probes the range boundary at CORE_CNT, a slot with no core fitted, extreme vectors, noise in the unused bits, and commands in consecutive cycles.

// File: rtl/ipi_router_pkg.sv
package ipi_router_pkg;
  localparam int unsigned CMD_W   = 32;
  localparam int unsigned ID_LSB  = 16;
  localparam int unsigned ID_W    = 10;
  localparam int unsigned VEC_LSB = 0;
  localparam int unsigned VEC_W   = 5;
  localparam int unsigned MASK_W  = 1 << VEC_W;

  typedef struct packed {
    logic [ID_W-1:0]  id;
    logic [VEC_W-1:0] vec;
  } cmd_fields_t;
endpackage

// File: rtl/ipi_cmd_field_extract.sv
module ipi_cmd_field_extract
  import ipi_router_pkg::*;
(
  input  logic [CMD_W-1:0] cmd_i,
  output cmd_fields_t      fields_o
);
  assign fields_o.id  = cmd_i[ID_LSB +: ID_W];
  assign fields_o.vec = cmd_i[VEC_LSB +: VEC_W];
endmodule

// File: rtl/ipi_target_check.sv
module ipi_target_check
  import ipi_router_pkg::*;
#(
  parameter int unsigned CORE_CNT = 4,
  parameter logic [CORE_CNT-1:0] POP_MASK = '1,
  localparam int unsigned IDX_W = (CORE_CNT > 1) ? $clog2(CORE_CNT) : 1
) (
  input  logic [ID_W-1:0]  id_i,
  output logic             ok_o,
  output logic [IDX_W-1:0] idx_o
);
  localparam int unsigned SLOTS = 1 << IDX_W;
  localparam logic [SLOTS-1:0] POP_EXT = SLOTS'(POP_MASK);

  logic in_range;
  assign in_range = (32'(id_i) < 32'(CORE_CNT));
  assign idx_o    = id_i[IDX_W-1:0];
  // direct index; unfitted and padded slots read as 0
  assign ok_o     = in_range && POP_EXT[idx_o];
endmodule

// File: rtl/ipi_vec_onehot.sv
module ipi_vec_onehot
  import ipi_router_pkg::*;
(
  input  logic [VEC_W-1:0]  vec_i,
  output logic [MASK_W-1:0] mask_o
);
  for (genvar b = 0; b < MASK_W; b++) begin : g_bit
    assign mask_o[b] = (vec_i == VEC_W'(b));
  end
endmodule

// File: rtl/ipi_cmd_router.sv
module ipi_cmd_router
  import ipi_router_pkg::*;
#(
  parameter int unsigned CORE_CNT = 4,
  parameter logic [CORE_CNT-1:0] POP_MASK = '1,
  localparam int unsigned IDX_W = (CORE_CNT > 1) ? $clog2(CORE_CNT) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_vld_i,
  input  logic [CMD_W-1:0]  cmd_i,
  output logic              set_vld_o,
  output logic [IDX_W-1:0]  set_core_o,
  output logic [MASK_W-1:0] set_mask_o,
  output logic              err_o
);
  cmd_fields_t       fields;
  logic              tgt_ok;
  logic [IDX_W-1:0]  tgt_idx;
  logic [MASK_W-1:0] vec_mask;

  ipi_cmd_field_extract i_extract (
    .cmd_i    (cmd_i),
    .fields_o (fields)
  );

  ipi_target_check #(
    .CORE_CNT (CORE_CNT),
    .POP_MASK (POP_MASK)
  ) i_check (
    .id_i  (fields.id),
    .ok_o  (tgt_ok),
    .idx_o (tgt_idx)
  );

  ipi_vec_onehot i_onehot (
    .vec_i  (fields.vec),
    .mask_o (vec_mask)
  );

  logic go, bad;
  assign go  = cmd_vld_i &&  tgt_ok;
  assign bad = cmd_vld_i && !tgt_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      set_vld_o  <= 1'b0;
      set_core_o <= '0;
      set_mask_o <= '0;
      err_o      <= 1'b0;
    end else begin
      set_vld_o  <= go;
      err_o      <= bad;
      set_mask_o <= go ? vec_mask : '0;
      if (go) set_core_o <= tgt_idx;
    end
  end
endmodule

// File: rtl/ipi_cmd_router_chk.sv
module ipi_cmd_router_chk
  import ipi_router_pkg::*;
#(
  parameter int unsigned CORE_CNT = 4,
  parameter int unsigned IDX_W = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cmd_vld_i,
  input logic [CMD_W-1:0]  cmd_i,
  input logic              set_vld_o,
  input logic [IDX_W-1:0]  set_core_o,
  input logic [MASK_W-1:0] set_mask_o,
  input logic              err_o
);
  p_onehot_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_vld_o |-> ($countones(set_mask_o) == 1));

  p_vec_pos_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_vld_i |=> (!set_vld_o || set_mask_o == (MASK_W'(1) << $past(cmd_i[4:0]))));

  p_core_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_vld_i |=> (!set_vld_o || 32'(set_core_o) == 32'($past(cmd_i[25:16]))));

  p_range_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_vld_o |-> (32'(set_core_o) < 32'(CORE_CNT)));

  p_excl_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(set_vld_o && err_o));

  p_err_nomask_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !set_vld_o |-> (set_mask_o == '0));

  p_idle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmd_vld_i |=> (!set_vld_o && !err_o));

  p_answer_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_vld_i |=> (set_vld_o || err_o));
endmodule

bind ipi_cmd_router ipi_cmd_router_chk #(
  .CORE_CNT (CORE_CNT),
  .IDX_W    (IDX_W)
) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cmd_vld_i  (cmd_vld_i),
  .cmd_i      (cmd_i),
  .set_vld_o  (set_vld_o),
  .set_core_o (set_core_o),
  .set_mask_o (set_mask_o),
  .err_o      (err_o)
);

// File: tb/test_ipi_cmd_router.sv
`timescale 1ns/1ps
module test_ipi_cmd_router;
  localparam int unsigned CORE_CNT = 6;
  localparam logic [CORE_CNT-1:0] POP_MASK = 6'b101111;
  localparam int unsigned IDX_W = 3;
  localparam int NROW = 8;

  // {cmd[41:10], vld[9], core[8:6], vec[5:1], err[0]}
  localparam logic [41:0] ROWS [NROW] = '{
    {32'h0000_0000, 1'b1, 3'd0, 5'd0,  1'b0},
    {32'h0003_001F, 1'b1, 3'd3, 5'd31, 1'b0},
    {32'h0005_0010, 1'b1, 3'd5, 5'd16, 1'b0},
    {32'h0004_0003, 1'b0, 3'd0, 5'd0,  1'b1},
    {32'h0006_0001, 1'b0, 3'd0, 5'd0,  1'b1},
    {32'h03FF_0002, 1'b0, 3'd0, 5'd0,  1'b1},
    {32'hFC02_FFE7, 1'b1, 3'd2, 5'd7,  1'b0},
    {32'h0001_0009, 1'b1, 3'd1, 5'd9,  1'b0}
  };
  string row_tag [NROW] = '{"R2", "R3", "R2", "R5", "R4", "R4", "R6", "R3"};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_vld = 1'b0;
  logic [31:0] cmd = '0;
  logic set_vld;
  logic [IDX_W-1:0] set_core;
  logic [31:0] set_mask;
  logic err;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  ipi_cmd_router #(.CORE_CNT(CORE_CNT), .POP_MASK(POP_MASK)) i_ipi_cmd_router (
    .clk_i(clk), .rst_ni(rst_n), .cmd_vld_i(cmd_vld), .cmd_i(cmd),
    .set_vld_o(set_vld), .set_core_o(set_core), .set_mask_o(set_mask), .err_o(err)
  );

  task automatic chk(input string tag, input logic ev, input logic [IDX_W-1:0] ec,
                     input logic [31:0] em, input logic ee);
    n_chk++;
    if (set_vld !== ev || err !== ee || set_mask !== em || (ev && set_core !== ec)) begin
      n_fail++;
      $display("FAIL %s: vld=%b core=%0d mask=%h err=%b expected vld=%b core=%0d mask=%h err=%b",
               tag, set_vld, set_core, set_mask, err, ev, ec, em, ee);
    end
  endtask

  initial begin
    #20;
    chk("R1", 1'b0, '0, '0, 1'b0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk("R1", 1'b0, '0, '0, 1'b0);
    n_chk++;
    if (set_core !== '0) begin
      n_fail++;
      $display("FAIL R1: core=%0d expected 0", set_core);
    end

    for (int r = 0; r < NROW; r++) begin
      cmd_vld = 1'b1; cmd = ROWS[r][41:10];
      @(negedge clk);
      cmd_vld = 1'b0; cmd = '0;
      chk(row_tag[r], ROWS[r][9], ROWS[r][8:6],
          ROWS[r][9] ? (32'h1 << ROWS[r][5:1]) : 32'h0, ROWS[r][0]);
      @(negedge clk);
      chk("R7", 1'b0, '0, '0, 1'b0);
    end

    // R2: pulse lasts a single cycle
    cmd_vld = 1'b1; cmd = 32'h0002_0004;
    @(negedge clk); cmd_vld = 1'b0;
    chk("R2", 1'b1, 3'd2, 32'h10, 1'b0);
    @(negedge clk);
    chk("R2", 1'b0, '0, '0, 1'b0);

    // R7: command word moves with strobe low
    cmd = 32'h0001_0001;
    @(negedge clk);
    chk("R7", 1'b0, '0, '0, 1'b0);

    // R8: back-to-back valid, error, valid
    cmd_vld = 1'b1; cmd = 32'h0000_001E;
    @(negedge clk); cmd = 32'h0006_0000;
    chk("R8", 1'b1, 3'd0, 32'h4000_0000, 1'b0);
    @(negedge clk); cmd = 32'h0005_0001;
    chk("R8", 1'b0, '0, '0, 1'b1);
    @(negedge clk); cmd_vld = 1'b0; cmd = '0;
    chk("R8", 1'b1, 3'd5, 32'h2, 1'b0);

    // R1: reset clears a pending pulse
    cmd_vld = 1'b1; cmd = 32'h0003_0003;
    @(negedge clk); cmd_vld = 1'b0;
    #1 rst_n = 1'b0; #1;
    chk("R1", 1'b0, '0, '0, 1'b0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk("R1", 1'b0, '0, '0, 1'b0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule